// File: doc/BRIEF.md
# Flat Address Aperture Translator

This block sits in the memory request path of a compute unit. It takes a 64-bit generic (flat) address and works out which of three spaces it targets. The spaces are per-lane scratch (private), work-group shared memory (local) and global memory. The decision uses two programmable aperture windows. Each window is 2^32 bytes long and starts on a 2^32 boundary, so the decode compares only the upper 32 bits of the address.

- A local hit returns the 32-bit offset inside the window.
- A private hit returns a physical scratch address, interleaved by dwords across the lanes of the wavefront.
- Anything else passes through as a global address, unchanged.

The block also converts in the other direction, from a 32-bit segment address back to a flat address. Null pointers are remapped in both directions, and the null value depends on the space.

Requests arrive on a valid/ready port. The result is held in a register one cycle after acceptance. The two aperture bases and the 64-bit scratch base are loaded through a small write port. That port only takes effect while the block is idle.

Top module: `flat_aperture_xlate`

## Requirements
- R1: Reset holds rsp_valid at 0 and clears both aperture bases and the scratch base to zero. With both bases at zero, a flat address whose upper 32 bits are zero decodes as local, because local wins over private.
- R2: req_ready equals (not rsp_valid) or rsp_ready. A request accepted on one clock edge is presented on rsp_valid/rsp_space/rsp_addr after that edge. If no new request is accepted, rsp_valid falls after an edge at which rsp_ready is high.
- R3: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_space and rsp_addr hold their values.
- R4: Flat-to-segment (req_to_flat=0) with a non-zero address whose upper 32 bits equal the local base gives rsp_space=1 and rsp_addr = {32'h0, address[31:0]}.
- R5: Flat-to-segment with a non-zero address whose upper 32 bits equal the private base, and not the local base, gives rsp_space=2. rsp_addr is the scratch base + offset*lanes*4 + lane*4, modulo 2^64, where offset is address[31:0].
- R6: req_wave64=1 selects 64 lanes and uses all six bits of req_lane. req_wave64=0 selects 32 lanes and ignores req_lane[5].
- R7: Flat-to-segment with an address in neither aperture gives rsp_space=0 and the address unchanged.
- R8: Flat-to-segment with address 0 returns the null of the space named by req_space, before any aperture decode:
  - space 1 (local): rsp_space=1, rsp_addr=32'hFFFF_FFFF;
  - space 2 (private): rsp_space=2, rsp_addr=0;
  - space 0 or 3: rsp_space=0, rsp_addr=0.
- R9: Segment-to-flat (req_to_flat=1) with req_space=1 maps req_addr[31:0]=32'hFFFF_FFFF to flat 0. Any other offset maps to {local base, offset}. req_addr[63:32] is ignored. rsp_space is 1.
- R10: Segment-to-flat with req_space=2 maps offset 0 to flat 0 and any other offset to {private base, offset}. rsp_space is 2.
- R11: Segment-to-flat with req_space 0 or 3 passes the full 64-bit address through with rsp_space=0. rsp_space is never 3.
- R12: A write with cfg_we=1 loads cfg_wdata into the register chosen by cfg_sel:
  - 0: private base, upper 32 bits;
  - 1: local base, upper 32 bits;
  - 2: scratch base, bits 31:0;
  - 3: scratch base, bits 63:32.
  The write is ignored in any cycle where req_valid or rsp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_to_flat | input | 1 | 0: flat to segment, 1: segment to flat |
| req_space | input | 2 | Target/source space: 0 global, 1 local, 2 private |
| req_addr | input | 64 | Flat address, or segment address in bits 31:0 |
| req_lane | input | 6 | Lane id within the wavefront |
| req_wave64 | input | 1 | 1: 64-lane wavefront, 0: 32-lane |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_space | output | 2 | Decoded space: 0 global, 1 local, 2 private |
| rsp_addr | output | 64 | Translated address |

## Verification
Several properties are checked on every cycle:
- the output holds while stalled;
- an accepted request always produces a result on the next cycle;
- a reported space is never the reserved code;
- a local result from flat decode has a zero upper half;
- a private result keeps the scratch base's dword alignment;
- configuration stays fixed while a request is pending or held.

Only the bench scenarios can show the values themselves:
- the interleave arithmetic in both wavefront sizes, including the ignored lane bit;
- the per-space null mapping;
- local-over-private priority after reset;
- a base write attempted during a stall being dropped, shown by the next translation.

// File: rtl/fat_pkg.sv
// Package: shared space codes and configuration selects for the flat
// address aperture translator. Assumes a 64-bit flat and 32-bit segment space.
package fat_pkg;

    typedef enum logic [1:0] {
        SP_GLOBAL  = 2'd0,
        SP_LOCAL   = 2'd1,
        SP_PRIVATE = 2'd2,
        SP_RSVD    = 2'd3
    } space_e;

    localparam logic [1:0] CFG_PRIV_HI = 2'd0;
    localparam logic [1:0] CFG_LOC_HI  = 2'd1;
    localparam logic [1:0] CFG_SCR_LO  = 2'd2;
    localparam logic [1:0] CFG_SCR_HI  = 2'd3;

endpackage

// File: rtl/fat_cfg_regs.sv
// Module: holds the two aperture bases (upper halves) and the scratch base.
// Assumes ADDR_W == 2*SEG_W so each register half is one write word wide.
// Writes are dropped while busy is high.
module fat_cfg_regs
    import fat_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SEG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [SEG_W-1:0]  wdata,
    input  logic              busy,
    output logic [SEG_W-1:0]  priv_hi,
    output logic [SEG_W-1:0]  loc_hi,
    output logic [ADDR_W-1:0] scratch_base
);
    localparam int HI_W = ADDR_W - SEG_W;

    logic [SEG_W-1:0] scr_lo_q;
    logic [HI_W-1:0]  scr_hi_q;
    logic             wr_ok;

    // Purpose: a write only lands while no request is pending or held.
    assign wr_ok = we && !busy;

    // Purpose: load the selected configuration word, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_hi  <= '0;
            loc_hi   <= '0;
            scr_lo_q <= '0;
            scr_hi_q <= '0;
        end else if (wr_ok) begin
            case (sel)
                CFG_PRIV_HI: priv_hi  <= wdata;
                CFG_LOC_HI:  loc_hi   <= wdata;
                CFG_SCR_LO:  scr_lo_q <= wdata;
                default:     scr_hi_q <= wdata[HI_W-1:0];
            endcase
        end
    end

    assign scratch_base = {scr_hi_q, scr_lo_q};

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({priv_hi, loc_hi, scratch_base})) // R12
        else $error("configuration changed while busy");

endmodule

// File: rtl/fat_scratch_addr.sv
// Module: forms the lane-interleaved scratch address
// base + offset*lanes*4 + lane*4. Assumes the lane count is 2^LANE_W
// (wave64) or half of it, and that the result wraps at ADDR_W bits.
module fat_scratch_addr #(
    parameter int ADDR_W = 64,
    parameter int SEG_W  = 32,
    parameter int LANE_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SEG_W-1:0]  offset,
    input  logic [LANE_W-1:0] lane,
    input  logic              wave64,
    output logic [ADDR_W-1:0] phys
);
    localparam int DW_SH = 2;
    localparam int SH_WIDE = LANE_W + DW_SH;
    localparam int SH_NARROW = LANE_W - 1 + DW_SH;

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] stride;
    logic [LANE_W-1:0] lane_eff;
    logic [ADDR_W-1:0] lane_ext;

    // Purpose: scale the offset by the wavefront's byte stride per dword row.
    always_comb begin
        off_ext  = {{(ADDR_W-SEG_W){1'b0}}, offset};
        stride   = wave64 ? (off_ext << SH_WIDE) : (off_ext << SH_NARROW);
        lane_eff = wave64 ? lane : {1'b0, lane[LANE_W-2:0]};
        lane_ext = {{(ADDR_W-LANE_W-DW_SH){1'b0}}, lane_eff, {DW_SH{1'b0}}};
        phys     = base + stride + lane_ext;
    end

endmodule

// File: rtl/fat_decode.sv
// Module: combinational space decode and address conversion in both
// directions, with per-space null handling. Assumes 2^SEG_W-sized apertures
// aligned to 2^SEG_W; local takes priority if both bases are equal.
module fat_decode
    import fat_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SEG_W  = 32,
    parameter int LANE_W = 6
) (
    input  logic              to_flat,
    input  logic [1:0]        space_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] lane,
    input  logic              wave64,
    input  logic [SEG_W-1:0]  priv_hi,
    input  logic [SEG_W-1:0]  loc_hi,
    input  logic [ADDR_W-1:0] scratch_base,
    output space_e            space_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - SEG_W;

    logic [HI_W-1:0]   hi;
    logic [SEG_W-1:0]  lo;
    logic [ADDR_W-1:0] scr_phys;

    assign hi = addr[ADDR_W-1:SEG_W];
    assign lo = addr[SEG_W-1:0];

    fat_scratch_addr #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .LANE_W(LANE_W)) scr_i (
        .base   (scratch_base),
        .offset (lo),
        .lane   (lane),
        .wave64 (wave64),
        .phys   (scr_phys)
    );

    // Purpose: pick the target space and the converted address.
    always_comb begin
        space_o = SP_GLOBAL;
        addr_o  = addr;
        if (!to_flat) begin
            if (addr == '0) begin
                case (space_in)
                    SP_LOCAL: begin
                        space_o = SP_LOCAL;
                        addr_o  = {{HI_W{1'b0}}, {SEG_W{1'b1}}};
                    end
                    SP_PRIVATE: begin
                        space_o = SP_PRIVATE;
                        addr_o  = '0;
                    end
                    default: begin
                        space_o = SP_GLOBAL;
                        addr_o  = '0;
                    end
                endcase
            end else if (hi == loc_hi) begin
                space_o = SP_LOCAL;
                addr_o  = {{HI_W{1'b0}}, lo};
            end else if (hi == priv_hi) begin
                space_o = SP_PRIVATE;
                addr_o  = scr_phys;
            end
        end else begin
            case (space_in)
                SP_LOCAL: begin
                    space_o = SP_LOCAL;
                    addr_o  = (lo == {SEG_W{1'b1}}) ? '0 : {loc_hi, lo};
                end
                SP_PRIVATE: begin
                    space_o = SP_PRIVATE;
                    addr_o  = (lo == '0) ? '0 : {priv_hi, lo};
                end
                default: begin
                    space_o = SP_GLOBAL;
                    addr_o  = addr;
                end
            endcase
        end
    end

endmodule

// File: rtl/flat_aperture_xlate.sv
// Module: top of the flat address aperture translator. Accepts one request
// per cycle on valid/ready and presents the converted address from a
// register one cycle later. Assumes configuration is written only while idle.
module flat_aperture_xlate
    import fat_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SEG_W  = 32,
    parameter int LANE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [SEG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_to_flat,
    input  logic [1:0]        req_space,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANE_W-1:0] req_lane,
    input  logic              req_wave64,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_space,
    output logic [ADDR_W-1:0] rsp_addr
);
    localparam int HI_W = ADDR_W - SEG_W;

    logic [SEG_W-1:0]  priv_hi;
    logic [SEG_W-1:0]  loc_hi;
    logic [ADDR_W-1:0] scratch_base;
    space_e            dec_space;
    logic [ADDR_W-1:0] dec_addr;
    logic              accept;
    logic              dir_q;
    space_e            space_q;

    fat_cfg_regs #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (cfg_we),
        .sel          (cfg_sel),
        .wdata        (cfg_wdata),
        .busy         (req_valid || rsp_valid),
        .priv_hi      (priv_hi),
        .loc_hi       (loc_hi),
        .scratch_base (scratch_base)
    );

    fat_decode #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .LANE_W(LANE_W)) dec_i (
        .to_flat      (req_to_flat),
        .space_in     (req_space),
        .addr         (req_addr),
        .lane         (req_lane),
        .wave64       (req_wave64),
        .priv_hi      (priv_hi),
        .loc_hi       (loc_hi),
        .scratch_base (scratch_base),
        .space_o      (dec_space),
        .addr_o       (dec_addr)
    );

    // Purpose: accept a new request whenever the output slot is free or draining.
    assign req_ready = !rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    // Purpose: capture the converted result and manage the output valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            space_q   <= SP_GLOBAL;
            dir_q     <= 1'b0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= dec_addr;
            space_q   <= dec_space;
            dir_q     <= req_to_flat;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    assign rsp_space = space_q;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_space))) // R3
        else $error("output changed while stalled");

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready && rst_n) |-> rsp_valid) // R2
        else $error("accepted request produced no result");

    AST_NO_RSVD_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_space != SP_RSVD)) // R11
        else $error("reserved space code on output");

    AST_LOCAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !dir_q && rsp_space == SP_LOCAL) |-> (rsp_addr[ADDR_W-1:SEG_W] == {HI_W{1'b0}})) // R4
        else $error("local segment result has non-zero upper half");

    AST_SCRATCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !dir_q && rsp_space == SP_PRIVATE && rsp_addr != '0)
            |-> (rsp_addr[1:0] == scratch_base[1:0])) // R5
        else $error("scratch address lost dword alignment");

endmodule

// File: tb/flat_aperture_xlate_tb_top.sv
// Bench: behavioural reference model updated on every rising edge and
// compared against the design on every falling edge.
module flat_aperture_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_to_flat = 1'b0;
    logic [1:0]  req_space = 2'd0;
    logic [63:0] req_addr = 64'd0;
    logic [5:0]  req_lane = 6'd0;
    logic        req_wave64 = 1'b1;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_space;
    logic [63:0] rsp_addr;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // reference state
    bit          m_valid = 0;
    logic [63:0] m_addr = 0;
    logic [1:0]  m_space = 0;
    logic [31:0] m_priv = 0;
    logic [31:0] m_loc = 0;
    logic [63:0] m_scr = 0;

    flat_aperture_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_to_flat(req_to_flat), .req_space(req_space), .req_addr(req_addr),
        .req_lane(req_lane), .req_wave64(req_wave64), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_space(rsp_space), .rsp_addr(rsp_addr)
    );

    always #5 clk = ~clk;

    function automatic logic [65:0] expect_of(bit to_flat, int sp, logic [63:0] a,
                                              int lane, bit w64);
        longint unsigned lanes, off, res;
        logic [31:0] up, low;
        up = a[63:32];
        low = a[31:0];
        if (!to_flat) begin
            if (a == 64'd0) begin
                if (sp == 1) return {2'd1, 64'h0000_0000_FFFF_FFFF};
                if (sp == 2) return {2'd2, 64'd0};
                return {2'd0, 64'd0};
            end
            if (up == m_loc) return {2'd1, 32'd0, low};
            if (up == m_priv) begin
                lanes = w64 ? 64 : 32;
                off = longint'(low);
                res = m_scr + off * lanes * 4 + (longint'(lane) % lanes) * 4;
                return {2'd2, res};
            end
            return {2'd0, a};
        end
        if (sp == 1) return (low == 32'hFFFF_FFFF) ? {2'd1, 64'd0} : {2'd1, m_loc, low};
        if (sp == 2) return (low == 32'd0) ? {2'd2, 64'd0} : {2'd2, m_priv, low};
        return {2'd0, a};
    endfunction

    // reference model update
    always @(posedge clk) begin
        bit rdy;
        logic [65:0] e;
        if (!rst_n) begin
            m_valid = 0; m_addr = 0; m_space = 0;
            m_priv = 0; m_loc = 0; m_scr = 0;
        end else begin
            rdy = !m_valid || rsp_ready;
            if (cfg_we && !req_valid && !m_valid) begin
                case (cfg_sel)
                    2'd0: m_priv = cfg_wdata;
                    2'd1: m_loc = cfg_wdata;
                    2'd2: m_scr[31:0] = cfg_wdata;
                    default: m_scr[63:32] = cfg_wdata;
                endcase
            end
            if (req_valid && rdy) begin
                e = expect_of(req_to_flat, int'(req_space), req_addr, int'(req_lane), req_wave64);
                m_valid = 1; m_space = e[65:64]; m_addr = e[63:0];
            end else if (rsp_ready) begin
                m_valid = 0;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (req_ready !== (!m_valid || rsp_ready)) begin
                errors++;
                $display("FAIL %s R2 req_ready actual=%0b expected=%0b", cur_req, req_ready, !m_valid || rsp_ready);
            end
            checks++;
            if (rsp_valid !== m_valid) begin
                errors++;
                $display("FAIL %s rsp_valid actual=%0b expected=%0b", cur_req, rsp_valid, m_valid);
            end
            if (m_valid) begin
                checks++;
                if (rsp_space !== m_space || rsp_addr !== m_addr) begin
                    errors++;
                    $display("FAIL %s result actual=%0d/%h expected=%0d/%h",
                             cur_req, rsp_space, rsp_addr, m_space, m_addr);
                end
            end
        end else begin
            checks++;
            if (rsp_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1 rsp_valid in reset actual=%0b expected=0", rsp_valid);
            end
        end
    end

    task automatic send(input bit tf, input logic [1:0] sp, input logic [63:0] a,
                        input logic [5:0] ln, input bit w64);
        req_valid = 1; req_to_flat = tf; req_space = sp; req_addr = a;
        req_lane = ln; req_wave64 = w64;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #2;
        req_valid = 0;
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        idle(2);
        // R1: bases zero, local wins for upper half zero
        send(0, 2'd0, 64'h0000_0000_0000_1234, 6'd3, 1);
        idle(1);

        cur_req = "R12";
        cfg_write(2'd1, 32'h0001_0000);
        cfg_write(2'd0, 32'h0002_0000);
        cfg_write(2'd2, 32'h8000_0004);
        cfg_write(2'd3, 32'h0000_0010);

        cur_req = "R4";
        send(0, 2'd0, 64'h0001_0000_DEAD_BEE0, 6'd0, 1);
        cur_req = "R5";
        send(0, 2'd0, 64'h0002_0000_0000_0100, 6'd37, 1);
        send(0, 2'd1, 64'h0002_0000_FFFF_FFFF, 6'd63, 1);
        cur_req = "R6";
        send(0, 2'd0, 64'h0002_0000_0000_1234, 6'd37, 0);
        send(0, 2'd0, 64'h0002_0000_0000_0001, 6'd31, 0);
        cur_req = "R7";
        send(0, 2'd1, 64'h0003_0000_0000_0040, 6'd1, 1);
        send(0, 2'd2, 64'hFFFF_FFFF_0000_0000, 6'd1, 1);
        cur_req = "R8";
        send(0, 2'd1, 64'd0, 6'd0, 1);
        send(0, 2'd2, 64'd0, 6'd9, 1);
        send(0, 2'd0, 64'd0, 6'd0, 1);
        send(0, 2'd3, 64'd0, 6'd0, 1);
        cur_req = "R9";
        send(1, 2'd1, 64'h1234_5678_0000_ABCD, 6'd0, 1);
        send(1, 2'd1, 64'h0000_0000_FFFF_FFFF, 6'd0, 1);
        cur_req = "R10";
        send(1, 2'd2, 64'hAAAA_0000_0000_0000, 6'd0, 1);
        send(1, 2'd2, 64'h0000_0000_0000_0044, 6'd0, 1);
        cur_req = "R11";
        send(1, 2'd0, 64'h0123_4567_89AB_CDEF, 6'd0, 1);
        send(1, 2'd3, 64'hFEDC_BA98_7654_3210, 6'd0, 1);
        idle(1);

        cur_req = "R3";
        rsp_ready = 0;
        send(0, 2'd0, 64'h0001_0000_0000_0055, 6'd0, 1);
        idle(3);
        cur_req = "R2";
        fork
            send(0, 2'd0, 64'h0002_0000_0000_0002, 6'd4, 1);
            begin idle(3); rsp_ready = 1; end
        join
        idle(1);

        cur_req = "R12";
        rsp_ready = 0;
        send(0, 2'd0, 64'h0007_0000_0000_0000, 6'd0, 1);
        cfg_write(2'd1, 32'h0000_5555);
        idle(1);
        rsp_ready = 1;
        idle(1);
        send(0, 2'd0, 64'h0001_0000_0000_0077, 6'd0, 1);
        send(0, 2'd0, 64'h0000_5555_0000_0077, 6'd0, 1);
        idle(2);
        finish_run();
    end

endmodule